// File: doc/BRIEF.md
# Display Write FIFO Transfer Scheduler

This block keeps the write queue of a display processor as a circular list of run-length transfer descriptors, not as data words. A CPU or DMA source pushes a descriptor made of an item count and three type flags. Each memory access-slot pulse consumes one slot of the active descriptor. A byte transfer uses two slots for each item. Pushes of the same type are merged into the tail descriptor. CPU writes may overtake a queued background DMA. A new DMA command issued while a DMA is busy flushes everything.

A separate pending counter tracks the queued items that are not background DMA. It drives the full and empty indications. The counter and the active slot count together decide when three things release: the CPU write stall, the CPU read wait and the DMA-busy state. The cycle-to-slot timing, the video memory and the DMA data path stay outside. The block only sees a slot pulse each time the memory grants an access.

Top module: `wfifo_sched`

## Requirements
- R1: After reset the queue is empty: length 0, slot count 0, pending 0, empty high, and full, stall, wait, busy, background and running all low.
- R2: A push into an idle queue sets running and loads the slot count with count shifted left by flag bit 0 (the byte flag). The next 3 slot pulses are latency and consume nothing.
- R3: Each consuming slot pulse lowers the slot count by one. The pending total drops by one per finished item: every slot for word descriptors, and only on the slot that ends a pair for byte descriptors. Descriptors with flag bit 1 (background DMA) never touch the pending total.
- R4: Full is high while the pending total is 4 or more. Empty is high while it is 0.
- R5: When the slot count reaches zero, the head descriptor leaves and the next one is loaded. If none is left, running clears and the pending total is forced to 0.
- R6: A push whose three flags equal the tail's, made while running, is added to the tail descriptor. If the tail is the head, the scaled count is also added to the active slot count.
- R7: A push without flag bit 1 onto a tail with flag bit 1 goes ahead of that descriptor, which moves back one place. If the moved descriptor was active, its remaining slots are written back as items, and the new entry becomes active with a fresh 3-pulse latency.
- R8: A push is accepted only if its count is nonzero and fewer than 8 descriptors remain after this cycle's consumption. Otherwise it changes nothing.
- R9: An accepted CPU push (flags 2 and 1 clear) that leaves the pending total above 4 sets the write stall. A consuming pulse that leaves the total at 4 or less clears it. On such a pulse, DMA-busy also clears if neither a background DMA nor a fill is active.
- R10: A read request while the slot count is nonzero sets the read wait. A consuming pulse that empties the slot count clears it, and also clears DMA-busy and background-active unless a fill is active.
- R11: A DMA command sets DMA-busy and records its background and fill kinds, and clears stall and wait. If busy was already set, the queue is flushed in that cycle: length, slot count, pending total and running all go to zero. A push or slot pulse in a command cycle is ignored.
- R12: Slot pulses while idle change nothing. A push and a slot pulse in the same cycle are both applied, the push after the consumption.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pushValid | input | 1 | Push request |
| pushFlags | input | 3 | Bit 0 byte, bit 1 background DMA, bit 2 foreground DMA |
| pushCount | input | CNT_W | Items in the push |
| slotPulse | input | 1 | One memory access slot granted |
| readReq | input | 1 | CPU read request |
| dmaCmd | input | 1 | New DMA command strobe |
| dmaCmdBg | input | 1 | Command is a background DMA |
| dmaCmdFill | input | 1 | Command is a fill |
| fifoFull | output | 1 | Pending total at or above 4 |
| fifoEmpty | output | 1 | Pending total zero |
| cpuStall | output | 1 | CPU write stall |
| readWait | output | 1 | CPU read wait |
| dmaBusy | output | 1 | DMA in progress |
| bgDmaActive | output | 1 | Background DMA recorded |
| running | output | 1 | A descriptor is active |
| queueLen | output | LEN_W | Descriptors queued |
| activeSlots | output | SLOT_W | Slots left in the active descriptor |
| pendingTotal | output | TOT_W | Pending non-background items |

## Verification
Every output is a register, so each push, slot pulse, read request or command shows up on the outputs just after the next rising edge. The bench drives a cycle's inputs, waits for one edge, and samples 2 ns later before it changes anything. The three latency pulses after a start are walked one cycle at a time, and the slot count is checked to stay unchanged through them. Consumption is checked only from the fourth pulse on, so a latency that is one pulse short or long shows up as a wrong count.

// File: rtl/wfifo_pkg.sv
package wfifo_pkg;
  localparam int FLG_W    = 3;
  localparam int FLG_BYTE = 0;
  localparam int FLG_BG   = 1;
  localparam int FLG_FG   = 2;

  // control -> datapath
  typedef struct packed {
    logic flush;
    logic slot;
    logic push;
  } wfifo_strobe_t;

  // datapath -> control, all refer to this cycle's next state
  typedef struct packed {
    logic consumed;
    logic cpuPushAcc;
    logic lowWater;
    logic slotsZero;
  } wfifo_status_t;
endpackage

// File: rtl/wfifo_dpath.sv
module wfifo_dpath
  import wfifo_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int CNT_W    = 8,
  parameter int LAT      = 3,
  parameter int FULL_TH  = 4,
  parameter int STALL_TH = 4,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int LEN_W   = IDX_W + 1,
  localparam int DCNT_W  = CNT_W + IDX_W,
  localparam int SLOT_W  = DCNT_W + 1,
  localparam int TOT_W   = DCNT_W + 1,
  localparam int LAT_W   = $clog2(LAT + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  wfifo_strobe_t      stb,
  input  logic [FLG_W-1:0]   pushFlags,
  input  logic [CNT_W-1:0]   pushCount,
  output wfifo_status_t      st,
  output logic               fifoFull,
  output logic               fifoEmpty,
  output logic               running,
  output logic [LEN_W-1:0]   queueLen,
  output logic [SLOT_W-1:0]  activeSlots,
  output logic [TOT_W-1:0]   pendingTotal
);
  logic [DCNT_W-1:0] qCnt  [DEPTH];
  logic [FLG_W-1:0]  qFlg  [DEPTH];
  logic [DCNT_W-1:0] qCntN [DEPTH];
  logic [FLG_W-1:0]  qFlgN [DEPTH];
  logic [IDX_W-1:0]  head, headN, tail;
  logic [LEN_W-1:0]  len, lenN;
  logic [SLOT_W-1:0] slotCnt, slotN;
  logic [TOT_W-1:0]  total, totN;
  logic              runN;
  logic [LAT_W-1:0]  latCnt, latN;
  logic              consumed, pushAcc;

  always_comb begin
    qCntN = qCnt;
    qFlgN = qFlg;
    headN = head;
    lenN  = len;
    slotN = slotCnt;
    totN  = total;
    runN  = running;
    latN  = latCnt;
    tail  = '0;
    consumed = 1'b0;
    pushAcc  = 1'b0;
    if (stb.flush) begin
      lenN  = '0;
      slotN = '0;
      totN  = '0;
      runN  = 1'b0;
      latN  = '0;
    end else begin
      // consumption first
      if (stb.slot && running) begin
        if (latCnt != '0) begin
          latN = latCnt - LAT_W'(1);
        end else begin
          consumed = 1'b1;
          if (!qFlg[head][FLG_BG] && (!qFlg[head][FLG_BYTE] || slotCnt[0]))
            totN = total - TOT_W'(1);
          slotN = slotCnt - SLOT_W'(1);
          if (slotN == '0) begin
            headN = head + IDX_W'(1);
            lenN  = len - LEN_W'(1);
            if (lenN != '0) begin
              slotN = SLOT_W'(qCnt[headN]) << qFlg[headN][FLG_BYTE];
            end else begin
              runN = 1'b0;
              totN = '0;
            end
          end
        end
      end
      // then the push
      if (stb.push && pushCount != '0 && lenN < LEN_W'(DEPTH)) begin
        pushAcc = 1'b1;
        tail = headN + lenN[IDX_W-1:0] - IDX_W'(1);
        if (lenN != '0 && qFlgN[tail][FLG_BG] && !pushFlags[FLG_BG]) begin
          if (tail == headN) begin
            qCntN[tail + IDX_W'(1)] = DCNT_W'(slotN >> qFlgN[tail][FLG_BYTE]);
            runN = 1'b0;
          end else begin
            qCntN[tail + IDX_W'(1)] = qCntN[tail];
          end
          qFlgN[tail + IDX_W'(1)] = qFlgN[tail];
          tail = tail - IDX_W'(1);
        end
        if (runN && qFlgN[tail] == pushFlags) begin
          qCntN[tail] = qCntN[tail] + DCNT_W'(pushCount);
          if (tail == headN)
            slotN = slotN + (SLOT_W'(pushCount) << pushFlags[FLG_BYTE]);
        end else begin
          lenN = lenN + LEN_W'(1);
          tail = tail + IDX_W'(1);
          qCntN[tail] = DCNT_W'(pushCount);
          qFlgN[tail] = pushFlags;
        end
        if (!runN) begin
          runN  = 1'b1;
          latN  = LAT_W'(LAT);
          slotN = SLOT_W'(pushCount) << pushFlags[FLG_BYTE];
        end
        if (!pushFlags[FLG_BG])
          totN = totN + TOT_W'(pushCount);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        qCnt[i] <= '0;
        qFlg[i] <= '0;
      end
      head    <= '0;
      len     <= '0;
      slotCnt <= '0;
      total   <= '0;
      running <= 1'b0;
      latCnt  <= '0;
    end else begin
      qCnt    <= qCntN;
      qFlg    <= qFlgN;
      head    <= headN;
      len     <= lenN;
      slotCnt <= slotN;
      total   <= totN;
      running <= runN;
      latCnt  <= latN;
    end
  end

  assign st.consumed   = consumed;
  assign st.cpuPushAcc = pushAcc && !pushFlags[FLG_BG] && !pushFlags[FLG_FG];
  assign st.lowWater   = (totN <= TOT_W'(STALL_TH));
  assign st.slotsZero  = (slotN == '0);

  assign fifoFull     = (total >= TOT_W'(FULL_TH));
  assign fifoEmpty    = (total == '0);
  assign queueLen     = len;
  assign activeSlots  = slotCnt;
  assign pendingTotal = total;

  p_len_cap_r8: assert property (@(posedge clk) disable iff (!rstN)
    len <= LEN_W'(DEPTH));
  p_run_len_r5: assert property (@(posedge clk) disable iff (!rstN)
    running == (len != '0));
  p_idle_slot_r12: assert property (@(posedge clk) disable iff (!rstN)
    (!running && stb.slot && !stb.push) |=> (slotCnt == '0 && len == '0));
  p_flush_r11: assert property (@(posedge clk) disable iff (!rstN)
    stb.flush |=> (len == '0 && total == '0 && !running));
  p_start_lat_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!running && stb.push && !stb.flush && pushCount != '0) |=> (running && latCnt == LAT_W'(LAT)));
endmodule

// File: rtl/wfifo_ctrl.sv
module wfifo_ctrl
  import wfifo_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          pushValid,
  input  logic          slotPulse,
  input  logic          readReq,
  input  logic          dmaCmd,
  input  logic          dmaCmdBg,
  input  logic          dmaCmdFill,
  input  wfifo_status_t st,
  output wfifo_strobe_t stb,
  output logic          cpuStall,
  output logic          readWait,
  output logic          dmaBusy,
  output logic          bgDmaActive
);
  logic fillActive;
  logic stallN, waitN, busyN, bgN;

  assign stb.flush = dmaCmd && dmaBusy;
  assign stb.slot  = slotPulse && !dmaCmd;
  assign stb.push  = pushValid && !dmaCmd;

  always_comb begin
    stallN = cpuStall;
    waitN  = readWait;
    busyN  = dmaBusy;
    bgN    = bgDmaActive;
    if (st.consumed) begin
      if (st.lowWater) begin
        stallN = 1'b0;
        if (!bgDmaActive && !fillActive) busyN = 1'b0;
      end
      if (st.slotsZero) begin
        waitN = 1'b0;
        if (!fillActive) begin
          busyN = 1'b0;
          bgN   = 1'b0;
        end
      end
    end
    if (st.cpuPushAcc && !st.lowWater) stallN = 1'b1;
    if (readReq && !st.slotsZero) waitN = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cpuStall    <= 1'b0;
      readWait    <= 1'b0;
      dmaBusy     <= 1'b0;
      bgDmaActive <= 1'b0;
      fillActive  <= 1'b0;
    end else if (dmaCmd) begin
      cpuStall    <= 1'b0;
      readWait    <= 1'b0;
      dmaBusy     <= 1'b1;
      bgDmaActive <= dmaCmdBg;
      fillActive  <= dmaCmdFill;
    end else begin
      cpuStall    <= stallN;
      readWait    <= waitN;
      dmaBusy     <= busyN;
      bgDmaActive <= bgN;
    end
  end

  p_cmd_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    dmaCmd |=> dmaBusy);
  p_stall_rel_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cpuStall && !dmaCmd && st.consumed && st.lowWater) |=> !cpuStall);
  p_wait_rel_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!dmaCmd && st.consumed && st.slotsZero) |=> !readWait);
endmodule

// File: rtl/wfifo_sched.sv
module wfifo_sched
  import wfifo_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int CNT_W    = 8,
  parameter int LAT      = 3,
  parameter int FULL_TH  = 4,
  parameter int STALL_TH = 4,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int LEN_W   = IDX_W + 1,
  localparam int SLOT_W  = CNT_W + IDX_W + 1,
  localparam int TOT_W   = CNT_W + IDX_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushValid,
  input  logic [2:0]        pushFlags,
  input  logic [CNT_W-1:0]  pushCount,
  input  logic              slotPulse,
  input  logic              readReq,
  input  logic              dmaCmd,
  input  logic              dmaCmdBg,
  input  logic              dmaCmdFill,
  output logic              fifoFull,
  output logic              fifoEmpty,
  output logic              cpuStall,
  output logic              readWait,
  output logic              dmaBusy,
  output logic              bgDmaActive,
  output logic              running,
  output logic [LEN_W-1:0]  queueLen,
  output logic [SLOT_W-1:0] activeSlots,
  output logic [TOT_W-1:0]  pendingTotal
);
  wfifo_strobe_t stb;
  wfifo_status_t st;

  wfifo_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .slotPulse(slotPulse),
    .readReq(readReq), .dmaCmd(dmaCmd), .dmaCmdBg(dmaCmdBg), .dmaCmdFill(dmaCmdFill),
    .st(st), .stb(stb), .cpuStall(cpuStall), .readWait(readWait),
    .dmaBusy(dmaBusy), .bgDmaActive(bgDmaActive)
  );

  wfifo_dpath #(
    .DEPTH(DEPTH), .CNT_W(CNT_W), .LAT(LAT), .FULL_TH(FULL_TH), .STALL_TH(STALL_TH)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .pushFlags(pushFlags), .pushCount(pushCount),
    .st(st), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .running(running),
    .queueLen(queueLen), .activeSlots(activeSlots), .pendingTotal(pendingTotal)
  );
endmodule

// File: tb/test_wfifo_sched.sv
`timescale 1ns/1ps
module test_wfifo_sched;
  logic        clk = 1'b0;
  logic        rstN;
  logic        pushValid, slotPulse, readReq, dmaCmd, dmaCmdBg, dmaCmdFill;
  logic [2:0]  pushFlags;
  logic [7:0]  pushCount;
  logic        fifoFull, fifoEmpty, cpuStall, readWait, dmaBusy, bgDmaActive, running;
  logic [3:0]  queueLen;
  logic [11:0] activeSlots, pendingTotal;
  int nChecks = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  wfifo_sched i_wfifo_sched (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushFlags(pushFlags),
    .pushCount(pushCount), .slotPulse(slotPulse), .readReq(readReq),
    .dmaCmd(dmaCmd), .dmaCmdBg(dmaCmdBg), .dmaCmdFill(dmaCmdFill),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .cpuStall(cpuStall),
    .readWait(readWait), .dmaBusy(dmaBusy), .bgDmaActive(bgDmaActive),
    .running(running), .queueLen(queueLen), .activeSlots(activeSlots),
    .pendingTotal(pendingTotal)
  );

  typedef struct packed {
    logic        pv;
    logic [2:0]  fl;
    logic [7:0]  cnt;
    logic        sl;
    logic        rd;
    logic [3:0]  len;
    logic [11:0] slots;
    logic [11:0] tot;
    logic        full;
    logic        empty;
    logic        stall;
    logic        wt;
    logic        run;
  } vec_t;

  localparam int NV = 31;
  // each row is one cycle; expectations hold just after that cycle's edge
  localparam vec_t VEC [NV] = '{
    '{1'b1,3'd0,8'd2,1'b0,1'b0, 4'd1,12'd2,12'd2, 1'b0,1'b0,1'b0,1'b0,1'b1}, // R2 start
    '{1'b0,3'd0,8'd0,1'b1,1'b0, 4'd1,12'd2,12'd2, 1'b0,1'b0,1'b0,1'b0,1'b1}, // R2 latency
    '{1'b0,3'd0,8'd0,1'b1,1'b0, 4'd1,12'd2,12'd2, 1'b0,1'b0,1'b0,1'b0,1'b1},
    '{1'b0,3'd0,8'd0,1'b1,1'b0, 4'd1,12'd2,12'd2, 1'b0,1'b0,1'b0,1'b0,1'b1},
    '{1'b0,3'd0,8'd0,1'b1,1'b0, 4'd1,12'd1,12'd1, 1'b0,1'b0,1'b0,1'b0,1'b1}, // R3
    '{1'b1,3'd0,8'd5,1'b0,1'b0, 4'd1,12'd6,12'd6, 1'b1,1'b0,1'b1,1'b0,1'b1}, // R6 head merge, R9 stall
    '{1'b0,3'd0,8'd0,1'b1,1'b1, 4'd1,12'd5,12'd5, 1'b1,1'b0,1'b1,1'b1,1'b1}, // R10 wait
    '{1'b0,3'd0,8'd0,1'b1,1'b0, 4'd1,12'd4,12'd4, 1'b1,1'b0,1'b0,1'b1,1'b1}, // R9 release
    '{1'b0,3'd0,8'd0,1'b1,1'b0, 4'd1,12'd3,12'd3, 1'b0,1'b0,1'b0,1'b1,1'b1}, // R4
    '{1'b0,3'd0,8'd0,1'b1,1'b0, 4'd1,12'd2,12'd2, 1'b0,1'b0,1'b0,1'b1,1'b1},
    '{1'b0,3'd0,8'd0,1'b1,1'b0, 4'd1,12'd1,12'd1, 1'b0,1'b0,1'b0,1'b1,1'b1},
    '{1'b0,3'd0,8'd0,1'b1,1'b0, 4'd0,12'd0,12'd0, 1'b0,1'b1,1'b0,1'b0,1'b0}, // R5 drain
    '{1'b0,3'd0,8'd0,1'b1,1'b0, 4'd0,12'd0,12'd0, 1'b0,1'b1,1'b0,1'b0,1'b0}, // R12 idle slot
    '{1'b1,3'd1,8'd2,1'b0,1'b0, 4'd1,12'd4,12'd2, 1'b0,1'b0,1'b0,1'b0,1'b1}, // R2 byte
    '{1'b0,3'd0,8'd0,1'b1,1'b0, 4'd1,12'd4,12'd2, 1'b0,1'b0,1'b0,1'b0,1'b1},
    '{1'b0,3'd0,8'd0,1'b1,1'b0, 4'd1,12'd4,12'd2, 1'b0,1'b0,1'b0,1'b0,1'b1},
    '{1'b0,3'd0,8'd0,1'b1,1'b0, 4'd1,12'd4,12'd2, 1'b0,1'b0,1'b0,1'b0,1'b1},
    '{1'b0,3'd0,8'd0,1'b1,1'b0, 4'd1,12'd3,12'd2, 1'b0,1'b0,1'b0,1'b0,1'b1}, // R3 byte half
    '{1'b1,3'd1,8'd1,1'b1,1'b0, 4'd1,12'd4,12'd2, 1'b0,1'b0,1'b0,1'b0,1'b1}, // R12 push+slot
    '{1'b0,3'd0,8'd0,1'b1,1'b0, 4'd1,12'd3,12'd2, 1'b0,1'b0,1'b0,1'b0,1'b1},
    '{1'b0,3'd0,8'd0,1'b1,1'b0, 4'd1,12'd2,12'd1, 1'b0,1'b0,1'b0,1'b0,1'b1},
    '{1'b0,3'd0,8'd0,1'b1,1'b0, 4'd1,12'd1,12'd1, 1'b0,1'b0,1'b0,1'b0,1'b1},
    '{1'b0,3'd0,8'd0,1'b1,1'b0, 4'd0,12'd0,12'd0, 1'b0,1'b1,1'b0,1'b0,1'b0},
    '{1'b1,3'd0,8'd1,1'b0,1'b0, 4'd1,12'd1,12'd1, 1'b0,1'b0,1'b0,1'b0,1'b1},
    '{1'b1,3'd1,8'd1,1'b0,1'b0, 4'd2,12'd1,12'd2, 1'b0,1'b0,1'b0,1'b0,1'b1}, // R6 no merge
    '{1'b0,3'd0,8'd0,1'b1,1'b0, 4'd2,12'd1,12'd2, 1'b0,1'b0,1'b0,1'b0,1'b1},
    '{1'b0,3'd0,8'd0,1'b1,1'b0, 4'd2,12'd1,12'd2, 1'b0,1'b0,1'b0,1'b0,1'b1},
    '{1'b0,3'd0,8'd0,1'b1,1'b0, 4'd2,12'd1,12'd2, 1'b0,1'b0,1'b0,1'b0,1'b1},
    '{1'b0,3'd0,8'd0,1'b1,1'b0, 4'd1,12'd2,12'd1, 1'b0,1'b0,1'b0,1'b0,1'b1}, // R5 pop+load
    '{1'b0,3'd0,8'd0,1'b1,1'b0, 4'd1,12'd1,12'd1, 1'b0,1'b0,1'b0,1'b0,1'b1},
    '{1'b0,3'd0,8'd0,1'b1,1'b0, 4'd0,12'd0,12'd0, 1'b0,1'b1,1'b0,1'b0,1'b0}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic pv, input logic [2:0] fl, input logic [7:0] cnt,
                     input logic sl, input logic rd, input logic cmd,
                     input logic cbg, input logic cfl);
    pushValid = pv; pushFlags = fl; pushCount = cnt; slotPulse = sl;
    readReq = rd; dmaCmd = cmd; dmaCmdBg = cbg; dmaCmdFill = cfl;
    @(posedge clk);
    #2;
    pushValid = 1'b0; pushFlags = '0; pushCount = '0; slotPulse = 1'b0;
    readReq = 1'b0; dmaCmd = 1'b0; dmaCmdBg = 1'b0; dmaCmdFill = 1'b0;
  endtask

  task automatic slots(input int n);
    for (int k = 0; k < n; k++) cyc(1'b0, 3'd0, 8'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic push(input logic [2:0] fl, input logic [7:0] cnt);
    cyc(1'b1, fl, cnt, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #2000000;
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    pushValid = 1'b0; pushFlags = '0; pushCount = '0; slotPulse = 1'b0;
    readReq = 1'b0; dmaCmd = 1'b0; dmaCmdBg = 1'b0; dmaCmdFill = 1'b0;
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;

    // R1 reset state
    chk("R1", "len", queueLen, 0);
    chk("R1", "slots", activeSlots, 0);
    chk("R1", "total", pendingTotal, 0);
    chk("R1", "empty", fifoEmpty, 1);
    chk("R1", "full", fifoFull, 0);
    chk("R1", "flags", {cpuStall, readWait, dmaBusy, bgDmaActive, running}, 0);

    // table walk: R2 R3 R4 R5 R6 R9 R10 R12
    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i].pv, VEC[i].fl, VEC[i].cnt, VEC[i].sl, VEC[i].rd, 1'b0, 1'b0, 1'b0);
      chk("R5", $sformatf("row%0d len", i), queueLen, VEC[i].len);
      chk("R3", $sformatf("row%0d slots", i), activeSlots, VEC[i].slots);
      chk("R3", $sformatf("row%0d total", i), pendingTotal, VEC[i].tot);
      chk("R4", $sformatf("row%0d full", i), fifoFull, VEC[i].full);
      chk("R4", $sformatf("row%0d empty", i), fifoEmpty, VEC[i].empty);
      chk("R9", $sformatf("row%0d stall", i), cpuStall, VEC[i].stall);
      chk("R10", $sformatf("row%0d wait", i), readWait, VEC[i].wt);
      chk("R2", $sformatf("row%0d running", i), running, VEC[i].run);
    end

    // R7 overtake at head
    push(3'd2, 8'd3);
    chk("R3", "bg total excluded", pendingTotal, 0);
    slots(4);
    chk("R7", "bg slots before overtake", activeSlots, 2);
    push(3'd0, 8'd1);
    chk("R7", "len after overtake", queueLen, 2);
    chk("R7", "cpu entry active", activeSlots, 1);
    chk("R7", "total after overtake", pendingTotal, 1);
    slots(3);
    chk("R7", "restart latency", activeSlots, 1);
    slots(1);
    chk("R7", "bg remainder written back", activeSlots, 2);
    chk("R7", "len after cpu entry", queueLen, 1);
    slots(2);
    chk("R5", "drained after bg", queueLen, 0);

    // R7 overtake below head, merge with moved tail
    push(3'd0, 8'd1);
    push(3'd2, 8'd2);
    push(3'd0, 8'd1);
    chk("R7", "len after inner overtake", queueLen, 2);
    chk("R7", "head merge slots", activeSlots, 2);
    chk("R7", "total inner overtake", pendingTotal, 2);
    slots(5);
    chk("R7", "bg after cpu", activeSlots, 2);
    chk("R7", "len with bg only", queueLen, 1);
    slots(2);
    chk("R7", "drained", queueLen, 0);

    // R8 capacity, R9 stall set
    for (int k = 0; k < 8; k++) push(3'(k % 2), 8'd1);
    chk("R8", "len full", queueLen, 8);
    chk("R8", "total full", pendingTotal, 8);
    chk("R9", "stall after pushes", cpuStall, 1);
    push(3'd0, 8'd1);
    chk("R8", "ninth rejected len", queueLen, 8);
    chk("R8", "ninth rejected total", pendingTotal, 8);
    dmaCmdBg = 1'b0;
    cyc(1'b0, 3'd0, 8'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R11", "first cmd no flush", queueLen, 8);
    chk("R11", "busy set", dmaBusy, 1);
    chk("R11", "stall cleared", cpuStall, 0);
    cyc(1'b1, 3'd0, 8'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R11", "flush len", queueLen, 0);
    chk("R11", "flush slots", activeSlots, 0);
    chk("R11", "flush total", pendingTotal, 0);
    chk("R11", "flush running", running, 0);
    chk("R11", "busy kept", dmaBusy, 1);
    push(3'd0, 8'd0);
    chk("R8", "zero count ignored", queueLen, 0);

    // R9 busy release on low water
    push(3'd4, 8'd2);
    slots(3);
    chk("R9", "busy during latency", dmaBusy, 1);
    slots(1);
    chk("R9", "busy released", dmaBusy, 0);
    slots(1);
    chk("R5", "fg drained", queueLen, 0);

    // R10 background busy cleared at drain
    cyc(1'b0, 3'd0, 8'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R10", "bg active", bgDmaActive, 1);
    cyc(1'b1, 3'd2, 8'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R10", "wait set", readWait, 1);
    slots(3);
    chk("R10", "busy held", dmaBusy, 1);
    slots(1);
    chk("R10", "wait released", readWait, 0);
    chk("R10", "busy cleared", dmaBusy, 0);
    chk("R10", "bg cleared", bgDmaActive, 0);

    // R10 fill holds busy
    cyc(1'b0, 3'd0, 8'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    push(3'd0, 8'd1);
    slots(4);
    chk("R10", "fill keeps busy", dmaBusy, 1);
    chk("R10", "fill drained", queueLen, 0);

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule